// File: doc/BRIEF.md
# Refresh Scheduler with Postponement and Self-Refresh Control

This block lives inside a DDR memory controller and decides when auto-refresh commands must go to the device. A free-running interval counter produces one refresh credit every average refresh interval, which is 7.8 us for 8192 refreshes per 64 ms. An owed counter keeps track of how many refreshes are outstanding. Up to eight may be postponed. The block asks the command arbiter for a refresh and escalates to an urgent request before the postponement limit is reached. The arbiter must then put the refresh ahead of reads and writes.

The block also runs self-refresh. It issues the entry command with the clock enable driven low in the same cycle. It holds the clock enable low until an exit is requested. After exit it holds back commands in two windows: non-read commands wait for tRFC plus one clock, and reads wait for a fixed count of clocks. The clock frequency may change only while the device is in self-refresh, and the block flags that condition. The refresh interval and the refresh recovery time are parameters given in picoseconds. At elaboration they are rounded up to whole clock cycles.

The controller is built around five named states:
- **RUN**: normal operation.
- **RFC_WAIT**: recovery after an auto-refresh.
- **SELF_REF**: the device is in self-refresh.
- **XS_NONRD**: the first exit window, in which every command is blocked.
- **XS_READ**: the second exit window, in which only reads are blocked.

The transitions are:
- RUN to RFC_WAIT on an accepted grant.
- RUN to SELF_REF on a self-refresh entry.
- RFC_WAIT to RUN when its window expires.
- SELF_REF to XS_NONRD on an exit request.
- XS_NONRD to XS_READ when the non-read window expires.
- XS_READ to RUN when the read window expires.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, owed_cnt is 0, ref_req, ref_urgent, sr_cmd, cmd_block, read_block and clk_change_ok are 0, and cke is 1.
- R2: The interval counter produces a credit in the last cycle of every interval of REFI cycles (the first in cycle REFI-1 after reset). Outside self-refresh a credit raises owed_cnt by one in the next cycle, and owed_cnt saturates at 8 and never exceeds it.
- R3: ref_req is 1 exactly when the state is RUN and owed_cnt is at least 1.
- R4: ref_urgent is 1 exactly when ref_req is 1 and owed_cnt is at least 7.
- R5: A grant is accepted when ref_grant, ref_req and banks_idle are all 1, and it lowers owed_cnt by one (a credit in the same cycle cancels it out). A ref_grant while banks_idle is 0 is ignored and leaves owed_cnt and the state unchanged.
- R6: After an accepted grant, cmd_block is 1 for the next RFC-1 cycles and then returns to 0, so the next command can issue RFC cycles after the refresh.
- R7: In RUN, sr_enter_req with banks_idle at 1 and no accepted grant asserts sr_cmd with cke at 0 in the same cycle. cke then stays 0 up to and including the cycle in which sr_exit_req is seen.
- R8: Credits that arrive in SELF_REF are discarded, so owed_cnt holds its value there. owed_cnt is 0 in the cycle after the exit request.
- R9: From the cycle in which cke rises after self-refresh, cmd_block is 1 for RFC+1 cycles and read_block is 1 for XSRD_CYC cycles. read_block is also 1 whenever cmd_block is 1.
- R10: clk_change_ok is 1 exactly in the SELF_REF state, and in that state cke is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | All banks are precharged |
| ref_grant | input | 1 | Arbiter issues the auto-refresh this cycle |
| sr_enter_req | input | 1 | Request to enter self-refresh |
| sr_exit_req | input | 1 | Request to leave self-refresh |
| ref_req | output | 1 | Refresh is owed |
| ref_urgent | output | 1 | Refresh must take priority over reads and writes |
| sr_cmd | output | 1 | Issue the self-refresh entry command this cycle |
| cke | output | 1 | Clock enable level toward the device |
| cmd_block | output | 1 | No command may be issued this cycle |
| read_block | output | 1 | No read may be issued this cycle |
| clk_change_ok | output | 1 | Clock frequency may be changed |
| owed_cnt | output | $clog2(MAX_OWED+1) | Number of refreshes owed |

## Verification
The assertions watch the relations that hold on every cycle:
- the owed count never passes its ceiling, and it stays frozen during self-refresh;
- an accepted grant is always followed by a blocked cycle;
- cke is low whenever the entry command or the clock-change flag is up;
- a rise of cke opens a blocked window, and the read block always covers the command block.

The exact lengths of the two recovery windows, the interval timing of credits, the saturation at eight with escalation at seven, and the refusal of grants while banks are open can only be shown by the bench. It runs these scenarios against its own cycle model.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_RFC_WAIT = 3'd1,
        ST_SELF_REF = 3'd2,
        ST_XS_NONRD = 3'd3,
        ST_XS_READ  = 3'd4
    } sched_state_t;

    // Round a duration up to whole clock cycles.
    function automatic int unsigned cyc_ceil(input int unsigned t_ps,
                                             input int unsigned tck_ps);
        return (t_ps + tck_ps - 1) / tck_ps;
    endfunction

endpackage

// File: rtl/refsch_tick.sv
module refsch_tick #(
    parameter int unsigned PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

endmodule

// File: rtl/refsch_owed.sv
module refsch_owed #(
    parameter int unsigned MAX_OWED = 8,
    parameter int unsigned OW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          credit,
    input  logic          hold,
    input  logic          dec,
    input  logic          clr,
    output logic [OW-1:0] cnt
);
    localparam logic [OW-1:0] CAP = OW'(MAX_OWED);

    logic inc;
    assign inc = credit && !hold;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && !dec) begin
            if (cnt != CAP)
                cnt <= cnt + 1'b1;
        end else if (dec && !inc)
            cnt <= cnt - 1'b1;
    end

    AST_OWED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP); // R2
    AST_SR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr) |=> $stable(cnt)); // R8
    AST_EXIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R8

endmodule

// File: rtl/refsch_fsm.sv
module refsch_fsm
    import refsch_pkg::*;
#(
    parameter int unsigned OW        = 4,
    parameter int unsigned URGENT_AT = 7,
    parameter int unsigned RFC_CYC   = 14,
    parameter int unsigned XSNR_CYC  = 15,
    parameter int unsigned XSRD_CYC  = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [OW-1:0] owed,
    input  logic          banks_idle,
    input  logic          ref_grant,
    input  logic          sr_enter_req,
    input  logic          sr_exit_req,
    output logic          ref_req,
    output logic          ref_urgent,
    output logic          grant_ok,
    output logic          sr_cmd,
    output logic          cke,
    output logic          cmd_block,
    output logic          read_block,
    output logic          clk_change_ok,
    output logic          in_sr,
    output logic          sr_exit_fire
);
    localparam int unsigned WCW = $clog2(XSRD_CYC);
    localparam logic [OW-1:0]  URG_V   = OW'(URGENT_AT);
    localparam logic [WCW-1:0] RFC_LD  = WCW'(RFC_CYC - 2);
    localparam logic [WCW-1:0] XSN_LD  = WCW'(XSNR_CYC - 1);
    localparam logic [WCW-1:0] XSR_LD  = WCW'(XSRD_CYC - XSNR_CYC - 1);

    sched_state_t   st, st_n;
    logic [WCW-1:0] wc, wc_n;
    logic           sr_go;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_RUN;
            wc <= '0;
        end else begin
            st <= st_n;
            wc <= wc_n;
        end
    end

    // next state
    always_comb begin
        st_n = st;
        wc_n = wc;
        unique case (st)
            ST_RUN: begin
                if (grant_ok) begin
                    st_n = ST_RFC_WAIT;
                    wc_n = RFC_LD;
                end else if (sr_go) begin
                    st_n = ST_SELF_REF;
                end
            end
            ST_RFC_WAIT: begin
                if (wc == '0) st_n = ST_RUN;
                else          wc_n = wc - 1'b1;
            end
            ST_SELF_REF: begin
                if (sr_exit_req) begin
                    st_n = ST_XS_NONRD;
                    wc_n = XSN_LD;
                end
            end
            ST_XS_NONRD: begin
                if (wc == '0) begin
                    st_n = ST_XS_READ;
                    wc_n = XSR_LD;
                end else begin
                    wc_n = wc - 1'b1;
                end
            end
            ST_XS_READ: begin
                if (wc == '0) st_n = ST_RUN;
                else          wc_n = wc - 1'b1;
            end
            default: st_n = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        ref_req       = (st == ST_RUN) && (owed != '0);
        ref_urgent    = ref_req && (owed >= URG_V);
        grant_ok      = ref_req && ref_grant && banks_idle;
        sr_go         = (st == ST_RUN) && sr_enter_req && banks_idle && !grant_ok;
        sr_cmd        = sr_go;
        cke           = (st != ST_SELF_REF) && !sr_go;
        cmd_block     = (st == ST_RFC_WAIT) || (st == ST_SELF_REF) || (st == ST_XS_NONRD);
        read_block    = cmd_block || (st == ST_XS_READ);
        clk_change_ok = (st == ST_SELF_REF);
        in_sr         = (st == ST_SELF_REF);
        sr_exit_fire  = (st == ST_SELF_REF) && sr_exit_req;
    end

    AST_GRANT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        grant_ok |=> cmd_block); // R6
    AST_ENTRY_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sr_cmd |-> !cke); // R7
    AST_READ_COVERS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_block |-> read_block); // R9
    AST_EXIT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> cmd_block); // R9
    AST_CLKCHG_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_change_ok |-> !cke); // R10

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refsch_pkg::*;
#(
    parameter int unsigned TCK_PS    = 5000,
    parameter int unsigned TREFI_PS  = 7800000,
    parameter int unsigned TRFC_PS   = 70000,
    parameter int unsigned XSRD_CYC  = 200,
    parameter int unsigned MAX_OWED  = 8,
    parameter int unsigned URGENT_AT = 7,
    localparam int unsigned OW       = $clog2(MAX_OWED + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          banks_idle,
    input  logic          ref_grant,
    input  logic          sr_enter_req,
    input  logic          sr_exit_req,
    output logic          ref_req,
    output logic          ref_urgent,
    output logic          sr_cmd,
    output logic          cke,
    output logic          cmd_block,
    output logic          read_block,
    output logic          clk_change_ok,
    output logic [OW-1:0] owed_cnt
);
    localparam int unsigned REFI_CYC = cyc_ceil(TREFI_PS, TCK_PS);
    localparam int unsigned RFC_CYC  = cyc_ceil(TRFC_PS, TCK_PS);
    localparam int unsigned XSNR_CYC = RFC_CYC + 1;

    logic credit, grant_ok, in_sr, sr_exit_fire;

    refsch_tick #(.PERIOD(REFI_CYC)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (credit)
    );

    refsch_owed #(.MAX_OWED(MAX_OWED), .OW(OW)) u_owed (
        .clk   (clk),
        .rst_n (rst_n),
        .credit(credit),
        .hold  (in_sr),
        .dec   (grant_ok),
        .clr   (sr_exit_fire),
        .cnt   (owed_cnt)
    );

    refsch_fsm #(
        .OW       (OW),
        .URGENT_AT(URGENT_AT),
        .RFC_CYC  (RFC_CYC),
        .XSNR_CYC (XSNR_CYC),
        .XSRD_CYC (XSRD_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .owed         (owed_cnt),
        .banks_idle   (banks_idle),
        .ref_grant    (ref_grant),
        .sr_enter_req (sr_enter_req),
        .sr_exit_req  (sr_exit_req),
        .ref_req      (ref_req),
        .ref_urgent   (ref_urgent),
        .grant_ok     (grant_ok),
        .sr_cmd       (sr_cmd),
        .cke          (cke),
        .cmd_block    (cmd_block),
        .read_block   (read_block),
        .clk_change_ok(clk_change_ok),
        .in_sr        (in_sr),
        .sr_exit_fire (sr_exit_fire)
    );

endmodule

// File: tb/tb_refresh_sched.sv
`timescale 1ns/1ps
module tb_refresh_sched;
    localparam int REFI = 40;
    localparam int RFC  = 4;
    localparam int XSNR = RFC + 1;
    localparam int XSRD = 12;
    localparam int MAXO = 8;
    localparam int URG  = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic banks_idle = 1'b0, ref_grant = 1'b0, sr_enter_req = 1'b0, sr_exit_req = 1'b0;
    logic ref_req, ref_urgent, sr_cmd, cke, cmd_block, read_block, clk_change_ok;
    logic [3:0] owed_cnt;

    always #10 clk = ~clk;

    refresh_sched #(
        .TCK_PS(20000), .TREFI_PS(800000), .TRFC_PS(70000),
        .XSRD_CYC(XSRD), .MAX_OWED(MAXO), .URGENT_AT(URG)
    ) dut (
        .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .ref_grant(ref_grant),
        .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .sr_cmd(sr_cmd), .cke(cke),
        .cmd_block(cmd_block), .read_block(read_block),
        .clk_change_ok(clk_change_ok), .owed_cnt(owed_cnt)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    // model: 0 run, 1 refresh recovery, 2 self-refresh, 3 exit windows
    int m_tc, m_owed, m_st, m_el;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    function automatic bit f_req();
        return (m_st == 0) && (m_owed > 0);
    endfunction
    function automatic bit f_go();
        return (m_st == 0) && sr_enter_req && banks_idle && !(f_req() && ref_grant && banks_idle);
    endfunction
    function automatic bit f_blk();
        return (m_st == 1) || (m_st == 2) || (m_st == 3 && m_el < XSNR);
    endfunction

    always @(posedge clk) begin
        bit tick, g, go, ex;
        int n;
        if (!rst_n) begin
            m_tc = 0; m_owed = 0; m_st = 0; m_el = 0;
        end else begin
            tick = (m_tc == REFI - 1);
            m_tc = tick ? 0 : m_tc + 1;
            g  = f_req() && ref_grant && banks_idle;
            go = f_go();
            ex = (m_st == 2) && sr_exit_req;
            if (ex) m_owed = 0;
            else begin
                n = m_owed;
                if (tick && m_st != 2) n++;
                if (g) n--;
                if (n > MAXO) n = MAXO;
                m_owed = n;
            end
            case (m_st)
                0: if (g) begin m_st = 1; m_el = 0; end
                   else if (go) begin m_st = 2; m_el = 0; end
                1: if (m_el == RFC - 2) m_st = 0; else m_el++;
                2: if (ex) begin m_st = 3; m_el = 0; end
                default: if (m_el == XSRD - 1) m_st = 0; else m_el++;
            endcase
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(ref_req == f_req(), "R3 ref_req", ref_req, f_req());
            chk(ref_urgent == (f_req() && m_owed >= URG), "R4 ref_urgent", ref_urgent, f_req() && m_owed >= URG);
            chk(int'(owed_cnt) == m_owed, "R2/R5/R8 owed_cnt", owed_cnt, m_owed);
            chk(cmd_block == f_blk(), "R6/R9 cmd_block", cmd_block, f_blk());
            chk(read_block == (f_blk() || m_st == 3), "R9 read_block", read_block, f_blk() || m_st == 3);
            chk(sr_cmd == f_go(), "R7 sr_cmd", sr_cmd, f_go());
            chk(cke == (m_st != 2 && !f_go()), "R7 cke", cke, m_st != 2 && !f_go());
            chk(clk_change_ok == (m_st == 2), "R10 clk_change_ok", clk_change_ok, m_st == 2);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 200000);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    initial begin
        int unsigned s;
        s = $urandom(32'd2024);
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(owed_cnt == 0 && !ref_req && !ref_urgent && !sr_cmd, "R1 reset outputs", owed_cnt, 0);
        chk(cke && !cmd_block && !read_block && !clk_change_ok, "R1 reset cke/blocks", cke, 1);
        step(); rst_n = 1'b1; banks_idle = 1'b1;
        @(negedge clk);
        chk(owed_cnt == 0 && cke && !ref_req, "R1 first cycle after reset", owed_cnt, 0);
        // R2/R4: no grants, let refreshes pile up to saturation
        repeat (12 * REFI) step();
        @(negedge clk);
        chk(owed_cnt == 8, "R2 saturation at 8", owed_cnt, 8);
        chk(ref_urgent == 1'b1, "R4 urgent at saturation", ref_urgent, 1);
        // R5: grant with banks open is ignored
        step(); banks_idle = 1'b0; ref_grant = 1'b1;
        @(negedge clk);
        chk(!cmd_block, "R5 open-bank grant leaves state", cmd_block, 0);
        step(); ref_grant = 1'b0; banks_idle = 1'b1;
        @(negedge clk);
        chk(owed_cnt == 8, "R5 open-bank grant ignored", owed_cnt, 8);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            step();
            banks_idle   = ($urandom % 4) != 0;
            ref_grant    = ($urandom % 4) == 0;
            sr_enter_req = ($urandom % 200) == 0;
            sr_exit_req  = ($urandom % 20) == 0;
        end
        // self-refresh heavy mix
        for (int i = 0; i < 2500; i++) begin
            step();
            banks_idle   = ($urandom % 8) != 0;
            ref_grant    = ($urandom % 2) == 0;
            sr_enter_req = ($urandom % 10) == 0;
            sr_exit_req  = ($urandom % 8) == 0;
        end
        step();
        ref_grant = 0; sr_enter_req = 0; sr_exit_req = 0;
        repeat (5) step();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule